// File: doc/BRIEF.md
# Accumulator Compare and Complement Execute Unit

This block is the execute stage of a small 16-bit accumulator machine. It accepts one instruction word per clock on a valid/ready input and decodes it. It executes the word in a single cycle. The block holds the active accumulator, the E, S, Z and C flags, and a one-shot prefix byte. It supports five operations: an equality compare of the accumulator against an operand, a bitwise inversion of the accumulator, an inversion of the carry flag, a prefix-byte load, and an accumulator load. The accumulator load exists so the accumulator can be given a value.

Each source operand is 8 bits wide. It is either an immediate byte taken from the instruction word or the low byte of a register, which the block reads through a combinational register-read port. The block widens that byte to 16 bits using the prefix byte as the upper half. The prefix byte is valid only for the next recognised instruction and then returns to zero. Every instruction word that is not recognised is dropped and changes nothing. All results appear on registered outputs after the clock edge that accepts the instruction.

Top module: `acc_flag_exec`

## Requirements
- R1: While the synchronous reset is high, and on leaving it, the accumulator, the prefix byte and the E, S, Z and C flags are all zero. The ready output is low during reset and high otherwise.
- R2: A word with bits 14:8 = 7'b1111000 is a compare. It sets E to 1 when the accumulator equals the 16-bit operand and clears E otherwise. It leaves the accumulator, S, Z and C unchanged.
- R3: Bit 15 of an operand-taking word selects the source byte. With 0, the source is bits 7:0 of the word. With 1, `regSel` carries bits 7:0, `regRdEn` is high, and the source is `regByte`.
- R4: A word with bits 14:8 = 7'b0001011 loads the source byte into the prefix. The next recognised instruction uses the prefix as bits 15:8 of its operand. A prefix load changes no flag and does not change the accumulator.
- R5: Any recognised instruction other than a prefix load clears the prefix. After that, 8-bit sources are zero-extended.
- R6: The word 16'h8A1A inverts every accumulator bit. S becomes bit 15 of the result and Z becomes 1 when the result is zero. E and C are unchanged.
- R7: The word 16'hDA2A inverts C. The accumulator and the E, S and Z flags are unchanged.
- R8: A word with bits 14:8 = 7'b0001001 writes the 16-bit operand into the accumulator. No flag changes.
- R9: An unrecognised word, or any word presented with the valid input low, changes no state. A pending prefix stays pending.
- R10: Each accepted instruction takes one cycle. Its result is visible on the outputs after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word present |
| instrReady | output | 1 | Unit can accept a word this cycle |
| instr | input | 16 | Instruction word |
| regSel | output | 8 | Register index for a register source |
| regRdEn | output | 1 | Register read strobe |
| regByte | input | 8 | Low byte of the selected register, same cycle |
| acc | output | 16 | Active accumulator |
| flagE | output | 1 | Equal flag |
| flagS | output | 1 | Sign flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |

## Verification
The properties assume that `regByte` is a same-cycle function of `regSel`. They also assume the register file is outside the unit, so a register source can never alias the accumulator. Otherwise they treat `instr` as arbitrary. The stimulus keeps `regByte` tied to a fixed function of `regSel`. It raises `instrValid` only outside reset and holds every input stable across each rising edge. Random words mix recognised encodings with arbitrary values, so the dropped-word rule and a prefix held across dropped words both occur many times.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

  localparam int DATA_W = 16;
  localparam int SRC_W  = DATA_W / 2;
  localparam int OPC_W  = 7;

  // operand-taking opcodes live in bits 14:8, bit 15 picks the source
  localparam logic [OPC_W-1:0] OPC_CMP   = 7'b1111000;
  localparam logic [OPC_W-1:0] OPC_ACCLD = 7'b0001001;
  localparam logic [OPC_W-1:0] OPC_PFXLD = 7'b0001011;

  // fixed whole-word encodings
  localparam logic [DATA_W-1:0] WORD_CPL  = 16'h8A1A;
  localparam logic [DATA_W-1:0] WORD_CPLC = 16'hDA2A;

  typedef struct packed {
    logic cmpEn;
    logic cplEn;
    logic cplcEn;
    logic accLdEn;
    logic pfxLdEn;
    logic pfxClr;
    logic useReg;
  } exec_ctl_t;

endpackage

// File: rtl/acc_flag_ctrl.sv
module acc_flag_ctrl
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = acc_flag_pkg::DATA_W,
  localparam int SRC_W = DATA_W / 2
) (
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instr,
  output logic              instrReady,
  output exec_ctl_t         ctl,
  output logic [SRC_W-1:0]  regSel,
  output logic              regRdEn
);

  logic fire;
  logic isCmp, isCpl, isCplc, isAccLd, isPfxLd, usesSrc, known;
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = instr[DATA_W-2 -: OPC_W];
    isCpl   = (instr == WORD_CPL);
    isCplc  = (instr == WORD_CPLC);
    isCmp   = (opc == OPC_CMP);
    isAccLd = (opc == OPC_ACCLD);
    isPfxLd = (opc == OPC_PFXLD);
    usesSrc = isCmp | isAccLd | isPfxLd;
    known   = usesSrc | isCpl | isCplc;
    fire    = instrValid & ~rst;
  end

  always_comb begin
    instrReady  = ~rst;
    ctl.cmpEn   = fire & isCmp;
    ctl.cplEn   = fire & isCpl;
    ctl.cplcEn  = fire & isCplc;
    ctl.accLdEn = fire & isAccLd;
    ctl.pfxLdEn = fire & isPfxLd;
    ctl.pfxClr  = fire & known & ~isPfxLd;
    ctl.useReg  = instr[DATA_W-1];
    regSel      = instr[SRC_W-1:0];
    regRdEn     = fire & usesSrc & instr[DATA_W-1];
  end

endmodule

// File: rtl/acc_flag_dp.sv
module acc_flag_dp
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = acc_flag_pkg::DATA_W,
  localparam int SRC_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  exec_ctl_t         ctl,
  input  logic [SRC_W-1:0]  immByte,
  input  logic [SRC_W-1:0]  regByte,
  output logic [DATA_W-1:0] acc,
  output logic              flagE,
  output logic              flagS,
  output logic              flagZ,
  output logic              flagC
);

  logic [SRC_W-1:0]  pfxQ;
  logic [SRC_W-1:0]  srcByte;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] cplRes;

  always_comb begin
    srcByte = ctl.useReg ? regByte : immByte;
    operand = {pfxQ, srcByte};
    cplRes  = ~acc;
  end

  // prefix byte: loaded by its own op, consumed by any other known op
  always_ff @(posedge clk) begin
    if (rst)              pfxQ <= '0;
    else if (ctl.pfxLdEn) pfxQ <= srcByte;
    else if (ctl.pfxClr)  pfxQ <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)              acc <= '0;
    else if (ctl.accLdEn) acc <= operand;
    else if (ctl.cplEn)   acc <= cplRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagE <= 1'b0;
      flagS <= 1'b0;
      flagZ <= 1'b0;
      flagC <= 1'b0;
    end else begin
      if (ctl.cmpEn)  flagE <= (acc == operand);
      if (ctl.cplEn) begin
        flagS <= cplRes[DATA_W-1];
        flagZ <= (cplRes == '0);
      end
      if (ctl.cplcEn) flagC <= ~flagC;
    end
  end

endmodule

// File: rtl/acc_flag_exec.sv
module acc_flag_exec
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = acc_flag_pkg::DATA_W,
  localparam int SRC_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  output logic              instrReady,
  input  logic [DATA_W-1:0] instr,
  output logic [SRC_W-1:0]  regSel,
  output logic              regRdEn,
  input  logic [SRC_W-1:0]  regByte,
  output logic [DATA_W-1:0] acc,
  output logic              flagE,
  output logic              flagS,
  output logic              flagZ,
  output logic              flagC
);

  exec_ctl_t ctl;

  acc_flag_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .rst        (rst),
    .instrValid (instrValid),
    .instr      (instr),
    .instrReady (instrReady),
    .ctl        (ctl),
    .regSel     (regSel),
    .regRdEn    (regRdEn)
  );

  acc_flag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .immByte (instr[SRC_W-1:0]),
    .regByte (regByte),
    .acc     (acc),
    .flagE   (flagE),
    .flagS   (flagS),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

endmodule

// File: rtl/acc_flag_chk.sv
module acc_flag_chk
  import acc_flag_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              instrValid,
  input logic [DATA_W-1:0] instr,
  input logic              regRdEn,
  input logic [SRC_W-1:0]  regByte,
  input logic [DATA_W-1:0] acc,
  input logic              flagE,
  input logic              flagS,
  input logic              flagZ,
  input logic              flagC
);

  logic fire, isCmp, isCpl, isCplc, isAccLd, isPfxLd, known;
  logic pfxPending;
  logic [SRC_W-1:0] pfxVal;
  logic [SRC_W-1:0] src;

  always_comb begin
    fire    = instrValid & ~rst;
    isCmp   = instr[14:8] == OPC_CMP;
    isAccLd = instr[14:8] == OPC_ACCLD;
    isPfxLd = instr[14:8] == OPC_PFXLD;
    isCpl   = instr == WORD_CPL;
    isCplc  = instr == WORD_CPLC;
    known   = isCmp | isAccLd | isPfxLd | isCpl | isCplc;
    src     = instr[15] ? regByte : instr[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfxPending <= 1'b0;
      pfxVal     <= '0;
    end else if (fire && isPfxLd) begin
      pfxPending <= 1'b1;
      pfxVal     <= src;
    end else if (fire && known) begin
      pfxPending <= 1'b0;
      pfxVal     <= '0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc == '0 && !flagE && !flagS && !flagZ && !flagC));

  // R2
  cmp_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isCmp) |=> (acc == $past(acc) && flagS == $past(flagS) &&
                         flagZ == $past(flagZ) && flagC == $past(flagC)));

  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> !regRdEn);

  // R4
  pfx_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isCmp && pfxPending) |=>
      flagE == ($past(acc) == {$past(pfxVal), $past(src)}));

  // R5
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isCmp && !pfxPending) |=>
      flagE == ($past(acc) == {{SRC_W{1'b0}}, $past(src)}));

  // R6
  cpl_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isCpl) |=> (acc == ~$past(acc) && flagS == acc[DATA_W-1] &&
                         flagZ == (acc == '0) && flagE == $past(flagE) &&
                         flagC == $past(flagC)));

  // R7
  cpl_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isCplc) |=> (flagC != $past(flagC) && acc == $past(acc) &&
                          flagE == $past(flagE)));

  // R8
  acc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && isAccLd) |=> (flagE == $past(flagE) && flagS == $past(flagS) &&
                           flagZ == $past(flagZ) && flagC == $past(flagC)));

  // R9
  drop_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!instrValid || !known) |=> ($stable(acc) && $stable(flagE) && $stable(flagS) &&
                                 $stable(flagZ) && $stable(flagC)));

endmodule

bind acc_flag_exec acc_flag_chk u_chk (.*);

// File: tb/test_acc_flag_exec.sv
module test_acc_flag_exec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic        instrReady;
  logic [15:0] instr = 16'h0000;
  logic [7:0]  regSel;
  logic        regRdEn;
  logic [7:0]  regByte;
  logic [15:0] acc;
  logic        flagE, flagS, flagZ, flagC;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] mAcc = '0;
  logic [7:0]  mPfx = '0;
  logic        mE = 0, mS = 0, mZ = 0, mC = 0;

  always #2 clk = ~clk;  // 250 MHz

  // register file stand-in: low byte of register n is n + 0x11
  assign regByte = regSel + 8'h11;

  acc_flag_exec i_acc_flag_exec (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrReady(instrReady),
    .instr(instr), .regSel(regSel), .regRdEn(regRdEn), .regByte(regByte),
    .acc(acc), .flagE(flagE), .flagS(flagS), .flagZ(flagZ), .flagC(flagC)
  );

  task automatic compare(input string tag, input logic expReady);
    bit bad = 0;
    nVec++;
    if (acc !== mAcc) begin bad = 1; $display("FAIL %s acc actual %h expected %h", tag, acc, mAcc); end
    if (flagE !== mE) begin bad = 1; $display("FAIL %s E actual %b expected %b", tag, flagE, mE); end
    if (flagS !== mS) begin bad = 1; $display("FAIL %s S actual %b expected %b", tag, flagS, mS); end
    if (flagZ !== mZ) begin bad = 1; $display("FAIL %s Z actual %b expected %b", tag, flagZ, mZ); end
    if (flagC !== mC) begin bad = 1; $display("FAIL %s C actual %b expected %b", tag, flagC, mC); end
    if (instrReady !== expReady) begin
      bad = 1; $display("FAIL %s ready actual %b expected %b", tag, instrReady, expReady);
    end
    if (bad) nBad++;
  endtask

  // drive at a falling edge, predict, compare at the next falling edge
  task automatic exec(input logic v, input logic [15:0] w, input string tag);
    logic [7:0]  src;
    logic [15:0] opnd;
    instrValid = v;
    instr      = w;
    #0.5;
    if (v && w[15] && (w[14:8] == 7'b1111000 || w[14:8] == 7'b0001001 ||
                       w[14:8] == 7'b0001011)) begin
      nVec++;
      if (regRdEn !== 1'b1 || regSel !== w[7:0]) begin
        nBad++;
        $display("FAIL R3 regRdEn/regSel actual %b/%h expected 1/%h", regRdEn, regSel, w[7:0]);
      end
    end
    src  = w[15] ? (w[7:0] + 8'h11) : w[7:0];
    opnd = {mPfx, src};
    if (v) begin
      if (w == 16'h8A1A) begin
        mAcc = ~mAcc; mS = mAcc[15]; mZ = (mAcc == 16'h0); mPfx = '0;
      end else if (w == 16'hDA2A) begin
        mC = ~mC; mPfx = '0;
      end else if (w[14:8] == 7'b1111000) begin
        mE = (mAcc == opnd); mPfx = '0;
      end else if (w[14:8] == 7'b0001001) begin
        mAcc = opnd; mPfx = '0;
      end else if (w[14:8] == 7'b0001011) begin
        mPfx = src;
      end
    end
    @(negedge clk);
    compare(tag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0);
    rst = 1'b0;
    #0.5;
    compare("R1 after reset", 1'b1);
    @(negedge clk);

    exec(1, 16'h0945, "R8 load imm");          // acc 0045
    exec(1, 16'h0B01, "R4 prefix load");
    exec(1, 16'h0945, "R4 R8 load with prefix"); // acc 0145
    exec(1, 16'h7845, "R5 cmp zero-ext E=0");
    exec(1, 16'h0B01, "R4 prefix load");
    exec(1, 16'h7845, "R2 R4 cmp with prefix E=1");
    exec(1, 16'h8A1A, "R6 cpl 0145");
    exec(1, 16'h0BFF, "R4 prefix");
    exec(1, 16'h09FF, "R8 load FFFF");
    exec(1, 16'h8A1A, "R6 cpl FFFF to 0");
    exec(1, 16'h0B09, "R4 prefix");
    exec(1, 16'h0990, "R8 load 0990");
    exec(1, 16'h8A1A, "R6 cpl 0990 to F66F");
    exec(1, 16'hDA2A, "R7 carry toggle");
    exec(1, 16'hDA2A, "R7 carry toggle back");
    exec(1, 16'h0B02, "R9 prefix then drop");
    exec(1, 16'h1234, "R9 unknown word");
    exec(0, 16'h8A1A, "R9 valid low");
    exec(1, 16'h0933, "R9 prefix survived: acc 0233");
    exec(1, 16'h0945, "R8 load 0045");
    exec(1, 16'hF834, "R3 cmp reg byte 45");
    exec(1, 16'h8B34, "R3 prefix from reg");
    exec(1, 16'h8900, "R3 R10 load 4511");
    exec(1, 16'h7811, "R5 cmp after clear");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      int k = $urandom_range(0, 7);
      w = 16'($urandom);
      case (k)
        0: w = {w[15], 7'b1111000, w[7:0]};
        1: w = {w[15], 7'b0001001, w[7:0]};
        2: w = {w[15], 7'b0001011, w[7:0]};
        3: w = 16'h8A1A;
        4: w = 16'hDA2A;
        5: w = {1'b0, 7'b1111000, mAcc[7:0]};
        default: ;
      endcase
      exec(($urandom_range(0, 5) != 0), w, "R10 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule